// File: doc/BRIEF.md
# Strided Interleaved-Bank Vector Loader

This block carries out one vector load over an interleaved memory of eight banks. A load is described by three values: a 24-bit word address for the first element, an element count, and a signed 24-bit stride. Element i lives at word address start + i*stride, and the address wraps modulo 2^24. The block sends at most one request per cycle, strictly in element order. Each request goes to bank (address mod 8).

A bank that accepts a request is busy for six cycles. It returns the data twelve cycles after the request. When the next element's bank is still busy, that element waits, and every later element waits behind it. The time a load takes therefore depends on how the stride falls across the banks, and not only on the element count. The bank responders are part of the block. Word address A holds the word {A[7:0] XOR 8'h5A, A[23:0]}.

Returned words are written into an internal vector buffer at their element index. A caller reads the buffer through a combinational index port. A one-cycle done pulse marks the end of each load.

The load command arrives over a valid/ready handshake. A command is taken on a rising edge where start_valid and start_ready are both high. start_ready stays low from acceptance until the cycle in which done pulses. While start_ready is low, start_valid and the parameters are not looked at, so a caller that keeps valid asserted simply waits.

Top module: `vec_bank_loader`

## Requirements
- R1: start_ready is high exactly when no load is in progress. A command is accepted on an edge with start_valid and start_ready both high. While start_ready is low, start_valid and the command inputs are ignored.
- R2: Element i of a load reads word address (start_addr + i*start_stride) mod 2^24, where start_stride is two's complement.
- R3: Element i goes to bank (address mod 8). A bank that accepts a request cannot accept another for 6 cycles. A request to a busy bank waits, and all later elements wait with it. A request whose bank is free is never held back.
- R4: Data returns 12 cycles after its request. done pulses 13 cycles after the last element's request cycle. A 64-element load with stride 1 therefore shows done 76 cycles after the accepting edge.
- R5: A 64-element load with stride 32 uses a single bank and shows done 12 + 1 + 6*63 = 391 cycles after acceptance. Stride 0 with 5 elements takes 37 cycles.
- R6: A load of count 0 makes no requests, pulses done in the first cycle after acceptance, and leaves the buffer unchanged.
- R7: A count above 64 is treated as 64.
- R8: After done, buffer entry i (read as rd_data for rd_idx = i) holds {A[7:0] ^ 8'h5A, A} for the address A of element i. Entries at or above the count keep their previous contents.
- R9: After reset, start_ready is 1, done is 0 and every buffer entry reads 0.
- R10: done is high for exactly one cycle per accepted load, and start_ready is high in that same cycle.
- R11: A stride coprime with 8, for example 9 or a negative stride of -3, never stalls. A load of n elements then finishes in 12 + n cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Load command present |
| start_ready | output | 1 | Block idle, command can be taken |
| start_addr | input | 24 | Word address of element 0 |
| start_count | input | 7 | Element count, 0 to 64 (larger values become 64) |
| start_stride | input | 24 | Signed word stride between elements |
| rd_idx | input | 6 | Buffer entry to read |
| rd_data | output | 32 | Contents of buffer entry rd_idx |
| done | output | 1 | One-cycle pulse at the end of a load |

## Verification
A bank busy counter or issue pointer that goes wrong moves the done pulse and the rise of start_ready away from the cycle the reference predicts. A comparison on every clock shows that in the very cycle the pulse should have come. A wrong address step or bank choice puts a wrong word, or a stale one, into some buffer entry. That becomes visible as soon as the buffer is read back after done. A response pipeline that loses or duplicates an element either leaves an entry stale or sends the done pulse early, late or not at all.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  localparam int DEF_ADDR_W = 24;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_BANK_W = 3;
  localparam int DEF_BUSY   = 6;
  localparam int DEF_LAT    = 12;
  localparam int DEF_MAXEL  = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/vbl_issue.sv
module vbl_issue
  import vbl_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BANK_W = DEF_BANK_W,
  parameter int MAXEL  = DEF_MAXEL,
  localparam int BANKS = 1 << BANK_W,
  localparam int IDX_W = $clog2(MAXEL),
  localparam int CNT_W = $clog2(MAXEL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [ADDR_W-1:0] start_stride,
  input  logic [BANKS-1:0]  bank_free,
  input  logic              fin,
  output logic              req_valid,
  output logic [BANK_W-1:0] req_bank,
  output logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  req_idx,
  output logic              req_last,
  output logic              zero_done
);
  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  cnt_eff;

  assign cnt_eff     = (start_count > CNT_W'(MAXEL)) ? CNT_W'(MAXEL) : start_count;
  assign start_ready = (state_q == ST_IDLE);
  assign zero_done   = start_valid && start_ready && (cnt_eff == '0);

  assign req_bank  = addr_q[BANK_W-1:0];
  assign req_valid = (state_q == ST_ISSUE) && bank_free[req_bank];
  assign req_addr  = addr_q;
  assign req_idx   = idx_q;
  assign req_last  = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      left_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_valid && cnt_eff != '0) begin
            state_q  <= ST_ISSUE;
            addr_q   <= start_addr;
            stride_q <= start_stride;
            idx_q    <= '0;
            left_q   <= cnt_eff;
          end
        end
        ST_ISSUE: begin
          if (req_valid) begin
            addr_q <= addr_q + stride_q;
            idx_q  <= idx_q + IDX_W'(1);
            left_q <= left_q - CNT_W'(1);
            if (req_last) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (fin) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vbl_bank.sv
module vbl_bank
  import vbl_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int IDX_W  = $clog2(DEF_MAXEL),
  parameter int BUSY   = DEF_BUSY,
  parameter int LAT    = DEF_LAT,
  localparam int BW    = $clog2(BUSY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic              acc_last,
  output logic              free,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  logic [BW-1:0]     busy_q;
  logic              p_vld  [LAT];
  logic              p_last [LAT];
  logic [ADDR_W-1:0] p_addr [LAT];
  logic [IDX_W-1:0]  p_idx  [LAT];

  assign free = (busy_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else if (acc_valid) busy_q <= BW'(BUSY - 1);
    else if (busy_q != '0) busy_q <= busy_q - BW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < LAT; j++) begin
        p_vld[j]  <= 1'b0;
        p_last[j] <= 1'b0;
        p_addr[j] <= '0;
        p_idx[j]  <= '0;
      end
    end else begin
      p_vld[0]  <= acc_valid;
      p_last[0] <= acc_last;
      p_addr[0] <= acc_addr;
      p_idx[0]  <= acc_idx;
      for (int j = 1; j < LAT; j++) begin
        p_vld[j]  <= p_vld[j-1];
        p_last[j] <= p_last[j-1];
        p_addr[j] <= p_addr[j-1];
        p_idx[j]  <= p_idx[j-1];
      end
    end
  end

  assign rsp_valid = p_vld[LAT-1];
  assign rsp_last  = p_vld[LAT-1] && p_last[LAT-1];
  assign rsp_idx   = p_idx[LAT-1];
  assign rsp_data  = (DATA_W'(p_addr[LAT-1][7:0] ^ 8'h5A) << ADDR_W) | DATA_W'(p_addr[LAT-1]);
endmodule

// File: rtl/vbl_collect.sv
module vbl_collect
  import vbl_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int BANK_W = DEF_BANK_W,
  parameter int MAXEL  = DEF_MAXEL,
  localparam int BANKS = 1 << BANK_W,
  localparam int IDX_W = $clog2(MAXEL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANKS-1:0]  rsp_valid,
  input  logic [BANKS-1:0]  rsp_last,
  input  logic [IDX_W-1:0]  rsp_idx  [BANKS],
  input  logic [DATA_W-1:0] rsp_data [BANKS],
  input  logic              zero_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              fin,
  output logic              done
);
  logic [DATA_W-1:0] vbuf [MAXEL];
  logic [IDX_W-1:0]  w_idx;
  logic [DATA_W-1:0] w_data;

  assign fin = |(rsp_valid & rsp_last);

  always_comb begin
    w_idx  = '0;
    w_data = '0;
    for (int g = 0; g < BANKS; g++) begin
      w_idx  = w_idx  | (rsp_idx[g]  & {IDX_W{rsp_valid[g]}});
      w_data = w_data | (rsp_data[g] & {DATA_W{rsp_valid[g]}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      for (int e = 0; e < MAXEL; e++) vbuf[e] <= '0;
    end else begin
      done <= fin || zero_done;
      if (|rsp_valid) vbuf[w_idx] <= w_data;
    end
  end

  assign rd_data = vbuf[rd_idx];
endmodule

// File: rtl/vec_bank_loader.sv
module vec_bank_loader
  import vbl_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int BANK_W = DEF_BANK_W,
  parameter int BUSY   = DEF_BUSY,
  parameter int LAT    = DEF_LAT,
  parameter int MAXEL  = DEF_MAXEL,
  localparam int BANKS = 1 << BANK_W,
  localparam int IDX_W = $clog2(MAXEL),
  localparam int CNT_W = $clog2(MAXEL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [ADDR_W-1:0] start_stride,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic [BANKS-1:0]  bank_free;
  logic [BANKS-1:0]  rsp_valid;
  logic [BANKS-1:0]  rsp_last;
  logic [IDX_W-1:0]  rsp_idx  [BANKS];
  logic [DATA_W-1:0] rsp_data [BANKS];
  logic              req_valid, req_last, zero_done, fin;
  logic [BANK_W-1:0] req_bank;
  logic [ADDR_W-1:0] req_addr;
  logic [IDX_W-1:0]  req_idx;

  vbl_issue #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAXEL(MAXEL)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_addr(start_addr), .start_count(start_count), .start_stride(start_stride),
    .bank_free(bank_free), .fin(fin),
    .req_valid(req_valid), .req_bank(req_bank), .req_addr(req_addr),
    .req_idx(req_idx), .req_last(req_last), .zero_done(zero_done)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic sel;
    assign sel = req_valid && (req_bank == BANK_W'(g));
    vbl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
               .BUSY(BUSY), .LAT(LAT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(sel), .acc_addr(req_addr), .acc_idx(req_idx), .acc_last(req_last),
      .free(bank_free[g]),
      .rsp_valid(rsp_valid[g]), .rsp_idx(rsp_idx[g]),
      .rsp_data(rsp_data[g]), .rsp_last(rsp_last[g])
    );
  end

  vbl_collect #(.DATA_W(DATA_W), .BANK_W(BANK_W), .MAXEL(MAXEL)) u_collect (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last),
    .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .zero_done(zero_done), .rd_idx(rd_idx), .rd_data(rd_data),
    .fin(fin), .done(done)
  );
endmodule

// File: rtl/vbl_checker.sv
module vbl_checker #(
  parameter int BANK_W = 3,
  parameter int CNT_W  = 7,
  localparam int BANKS = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [CNT_W-1:0]  start_count,
  input logic              done,
  input logic              req_valid,
  input logic [BANK_W-1:0] req_bank,
  input logic [BANKS-1:0]  bank_free,
  input logic [BANKS-1:0]  rsp_valid
);
  // R3
  bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> bank_free[req_bank]);

  // R4
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  // R6
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && start_count == '0) |=> done);

  // R1
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_ready) |-> $past(start_valid));

  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);
endmodule

bind vec_bank_loader vbl_checker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .start_count(start_count), .done(done), .req_valid(req_valid),
  .req_bank(req_bank), .bank_free(bank_free), .rsp_valid(rsp_valid)
);

// File: tb/vec_bank_loader_bench.sv
`timescale 1ns/1ps
module vec_bank_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [23:0] start_addr = '0;
  logic [6:0]  start_count = '0;
  logic [23:0] start_stride = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vec_bank_loader u_vec_bank_loader (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_addr(start_addr), .start_count(start_count), .start_stride(start_stride),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a};
  endfunction

  // behavioural reference
  int          cyc = 0;
  bit          m_active = 0, m_issuing = 0, m_done = 0;
  logic [23:0] m_addr, m_stride;
  int          m_idx, m_left, m_last_t = -1;
  int          m_free [8];
  logic [31:0] exp_buf [64];

  initial begin
    for (int i = 0; i < 8; i++) m_free[i] = 0;
    for (int i = 0; i < 64; i++) exp_buf[i] = '0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      bit acc, nd;
      int n, b;
      acc = start_valid && !m_active;
      nd = 0;
      if (m_active && m_issuing) begin
        b = int'(m_addr[2:0]);
        if (cyc >= m_free[b]) begin
          exp_buf[m_idx] = mem_word(m_addr);
          m_free[b] = cyc + 6;
          if (m_left == 1) begin m_issuing = 0; m_last_t = cyc + 12; end
          m_addr = m_addr + m_stride;
          m_idx++;
          m_left--;
        end
      end
      if (m_active && !m_issuing && cyc == m_last_t) begin nd = 1; m_active = 0; end
      if (acc) begin
        n = (start_count > 64) ? 64 : int'(start_count);
        if (n == 0) nd = 1;
        else begin
          m_active = 1; m_issuing = 1; m_addr = start_addr;
          m_stride = start_stride; m_idx = 0; m_left = n;
        end
      end
      m_done = nd;
      cyc++;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if (start_ready !== !m_active) begin
        n_bad++;
        $display("FAIL R1 cycle %0d start_ready=%b expected %b", cyc, start_ready, !m_active);
      end
      n_cmp++;
      if (done !== m_done) begin
        n_bad++;
        $display("FAIL R10 cycle %0d done=%b expected %b", cyc, done, m_done);
      end
    end
  end

  task automatic check_buf(input string tag);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rd_idx = 6'(i);
      #1;
      if (rd_data !== exp_buf[i]) begin
        if (bad == 0)
          $display("FAIL %s entry %0d rd_data=%h expected %h", tag, i, rd_data, exp_buf[i]);
        bad++;
      end
    end
    n_cmp++;
    if (bad != 0) n_bad++;
  endtask

  task automatic run_load(input logic [23:0] a, input logic [6:0] n, input logic [23:0] s,
                          input int exp_lat, input bit hold, input string tag);
    int t0, lat;
    @(negedge clk);
    start_valid = 1; start_addr = a; start_count = n; start_stride = s;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    t0 = cyc;
    if (hold) begin
      start_addr = 24'h777777; start_count = 7'd5; start_stride = 24'd1;
      repeat (20) begin
        if (done) break;
        @(negedge clk);
      end
    end
    start_valid = 0;
    while (!done) @(negedge clk);
    lat = cyc - t0;
    if (exp_lat >= 0) begin
      n_cmp++;
      if (lat != exp_lat) begin
        n_bad++;
        $display("FAIL %s latency=%0d expected %0d", tag, lat, exp_lat);
      end
    end
    check_buf(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    n_cmp++;
    if (start_ready !== 1'b1 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 ready=%b done=%b expected 1 0", start_ready, done);
    end
    check_buf("R9");
    // R4 stride 1 full load
    run_load(24'h000100, 7'd64, 24'd1, 76, 0, "R4");
    // R5 single bank stride 32
    run_load(24'h001000, 7'd64, 24'd32, 391, 0, "R5");
    // R11 stride 9
    run_load(24'h0000A3, 7'd64, 24'd9, 76, 0, "R11");
    // R3 stride 2: four banks, stalls by busy time
    run_load(24'h000040, 7'd20, 24'd2, -1, 0, "R3");
    // R5 stride 0, same word repeatedly
    run_load(24'h000505, 7'd5, 24'd0, 37, 0, "R5");
    // R2 / R11 negative stride wrapping below zero
    run_load(24'h000005, 7'd10, 24'hFFFFFD, 22, 0, "R2");
    // R6 zero count: done next cycle, buffer unchanged
    run_load(24'h123456, 7'd0, 24'd1, 0, 0, "R6");
    // R7 count above 64 clamps
    run_load(24'h0A0000, 7'd100, 24'd3, 76, 0, "R7");
    // R8 short load keeps entries above count
    run_load(24'h0B0B00, 7'd3, 24'd5, 15, 0, "R8");
    // R1 held valid during a load is ignored
    run_load(24'h0C0000, 7'd40, 24'd7, 52, 1, "R1");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    finished = 1;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule